// File: doc/BRIEF.md
# Single-cycle carry-save floating accumulator

This block sums a stream of floating operands and takes a new operand on every clock. Operands are in a radix-2^32 internal format. Each operand is a 3-bit exponent and a 55-bit mantissa held as two words (sum and carry), so that the value is `(sum + carry) mod 2^55`. That value is read as a signed two's complement number and scaled by 2^(32*exponent). The running total lives in three registers: an exponent, a sum word and a carry word. These registers drive the outputs directly, and an external final adder resolves them later.

Mantissa alignment never uses a variable shifter. Because the exponent counts in steps of 32 bit positions, every alignment is a shift of either 0 or 32 bits. The block prepares four outcomes at the same time and picks one each cycle:
- load the operand when the total is zero;
- keep the larger side when the exponents are far apart;
- renormalise the total upward by 32 bits;
- add the two sides with at most one operand shifted right.

A 4:2 compressor merges the two mantissa pairs. An overflow of the merged value is fixed by one 32-bit arithmetic right shift and an exponent step.

Top module: `sca_acc`

## Requirements
- R1: With `rst_ni` low, the state (exponent, sum word, carry word) is zero at once. A clock edge with `clear_i` high zeroes the state whatever the value of `acc_en_i`.
- R2: A clock edge with `clear_i` low and `acc_en_i` low leaves all three state registers unchanged.
- R3: If the feedback value (`sum_o + carry_o`, taken mod 2^55) is zero, the next state is the incoming operand word for word. This rule takes priority over every exponent relation.
- R4: With equal exponents and no overflow, the next value is feedback plus incoming, and the exponent is unchanged.
- R5: If the two exponents differ by exactly 1 and no renormalisation applies (see R7), the smaller side is shifted. Its sum and carry words are each shifted right arithmetically by 32 bits, and the result takes the larger exponent.
- R6: The larger side is kept word for word in three cases. The incoming exponent may exceed the feedback exponent by 2 or more. The feedback exponent may exceed the incoming one by 3 or more. Or the feedback exponent may exceed it by exactly 2 with no renormalisation.
- R7: Renormalisation applies when three conditions hold: the feedback exponent is larger by 1 or 2, the feedback is nonzero, and bits 54 down to 22 of the feedback value are all equal (more than 31 redundant sign bits; exactly 31 does not qualify). Both feedback words then shift left by 32 bits. The incoming words shift right arithmetically by 32 bits only when the difference is 2. The base exponent is the feedback exponent minus 1.
- R8: After an add (R4, R5 or R7), let v be the merged value mod 2^55. If bit 54 of v differs from bit 53, the new sum word is v shifted right arithmetically by 32 bits, the new carry word is zero, and the exponent rises by one.
- R9: An exponent step at the maximum exponent 7 saturates at 7, and the shift of R8 still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the running state |
| acc_en_i | input | 1 | Accepts the operand on this edge when high |
| exp_i | input | 3 | Incoming exponent (radix 2^32) |
| sum_i | input | 55 | Incoming mantissa, sum word |
| carry_i | input | 55 | Incoming mantissa, carry word |
| exp_o | output | 3 | Running exponent |
| sum_o | output | 55 | Running mantissa, sum word |
| carry_o | output | 55 | Running mantissa, carry word |

## Verification
The outputs are the state registers themselves. A wrong path choice, a wrong shift or a missed overflow therefore shows on the ports one cycle after the operand that caused it. It shows as a wrong exponent or a wrong resolved value `sum_o + carry_o`. A fault that only changes how the value is split between the two words stays hidden until a later 32-bit right shift of the feedback turns that split into a value error. For this reason the bench follows each add with alignment steps that shift the feedback words separately. The zero-detect, the exact-31 sign boundary and the saturating exponent are each driven right at their edge, so that an error there changes the very next exponent.

// File: rtl/sca_pkg.sv
package sca_pkg;
  localparam int MANT_W = 55;
  localparam int EXP_W  = 3;
  localparam int BLK_SH = 32;

  typedef enum logic [1:0] {PATH_A, PATH_B, PATH_C, PATH_D} path_e;
  typedef enum logic [1:0] {ALN_NONE, ALN_IN, ALN_FB} aln_e;
endpackage

// File: rtl/sca_csa42.sv
module sca_csa42 #(
  parameter int W = sca_pkg::MANT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] t1, m1;

  // two 3:2 layers; carries dropped above bit W-1 (mod 2^W arithmetic)
  assign t1      = a_i ^ b_i ^ c_i;
  assign m1      = ((a_i & b_i) | (a_i & c_i) | (b_i & c_i)) << 1;
  assign sum_o   = t1 ^ m1 ^ d_i;
  assign carry_o = ((t1 & m1) | (t1 & d_i) | (m1 & d_i)) << 1;
endmodule

// File: rtl/sca_fb_probe.sv
module sca_fb_probe #(
  parameter int W  = sca_pkg::MANT_W,
  parameter int SH = sca_pkg::BLK_SH
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] carry_i,
  output logic         zero_o,
  output logic         renorm_o
);
  localparam int TOP_LO = W - SH - 1;

  logic [W-1:0]      val;
  logic [W-1:TOP_LO] top;

  assign val      = sum_i + carry_i;
  assign top      = val[W-1:TOP_LO];
  assign zero_o   = (val == '0);
  // more than SH-1 redundant sign bits: a left shift by SH keeps the value
  assign renorm_o = (&top) | ~(|top);
endmodule

// File: rtl/sca_path_sel.sv
module sca_path_sel
  import sca_pkg::*;
#(
  parameter int EW = sca_pkg::EXP_W
) (
  input  logic [EW-1:0] exp_fb_i,
  input  logic [EW-1:0] exp_in_i,
  input  logic          zero_i,
  input  logic          renorm_i,
  output path_e         path_o,
  output aln_e          aln_o,
  output logic          c_shift_in_o,
  output logic          keep_in_o,
  output logic [EW-1:0] exp_base_o
);
  logic [EW-1:0] d_fi, d_if;

  assign d_fi = exp_fb_i - exp_in_i;
  assign d_if = exp_in_i - exp_fb_i;

  always_comb begin
    path_o       = PATH_A;
    aln_o        = ALN_NONE;
    c_shift_in_o = 1'b0;
    keep_in_o    = 1'b0;
    exp_base_o   = exp_fb_i;
    if (zero_i) begin
      path_o     = PATH_D;
      exp_base_o = exp_in_i;
    end else if (exp_fb_i > exp_in_i) begin
      if (d_fi == EW'(1)) begin
        if (renorm_i) begin
          path_o     = PATH_C;
          exp_base_o = exp_fb_i - EW'(1);
        end else begin
          aln_o = ALN_IN;
        end
      end else if (d_fi == EW'(2) && renorm_i) begin
        path_o       = PATH_C;
        c_shift_in_o = 1'b1;
        exp_base_o   = exp_fb_i - EW'(1);
      end else begin
        path_o = PATH_B;
      end
    end else if (exp_in_i > exp_fb_i) begin
      exp_base_o = exp_in_i;
      if (d_if == EW'(1)) begin
        aln_o = ALN_FB;
      end else begin
        path_o    = PATH_B;
        keep_in_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sca_merge.sv
module sca_merge
  import sca_pkg::*;
#(
  parameter int W  = sca_pkg::MANT_W,
  parameter int SH = sca_pkg::BLK_SH,
  parameter int EW = sca_pkg::EXP_W
) (
  input  logic [W-1:0]  s_fb_i,
  input  logic [W-1:0]  c_fb_i,
  input  logic [W-1:0]  s_in_i,
  input  logic [W-1:0]  c_in_i,
  input  path_e         path_i,
  input  aln_e          aln_i,
  input  logic          c_shift_in_i,
  input  logic [EW-1:0] exp_base_i,
  output logic [W-1:0]  s_res_o,
  output logic [W-1:0]  c_res_o,
  output logic [EW-1:0] exp_res_o
);
  localparam int          NA      = 3;
  localparam logic [EW-1:0] EXP_MAX = '1;

  function automatic logic [W-1:0] sra32(input logic [W-1:0] x);
    return {{SH{x[W-1]}}, x[W-1:SH]};
  endfunction

  function automatic logic [W-1:0] shl32(input logic [W-1:0] x);
    return {x[W-SH-1:0], {SH{1'b0}}};
  endfunction

  logic [W-1:0] s_a [NA];
  logic [W-1:0] c_a [NA];

  // path A: the three shift combinations compressed in parallel
  for (genvar k = 0; k < NA; k++) begin : g_path_a
    localparam bit SHIFT_IN = (k == 1);
    localparam bit SHIFT_FB = (k == 2);
    logic [W-1:0] fa, fb, ia, ib;
    assign fa = SHIFT_FB ? sra32(s_fb_i) : s_fb_i;
    assign fb = SHIFT_FB ? sra32(c_fb_i) : c_fb_i;
    assign ia = SHIFT_IN ? sra32(s_in_i) : s_in_i;
    assign ib = SHIFT_IN ? sra32(c_in_i) : c_in_i;
    sca_csa42 #(.W(W)) u_csa (
      .a_i(fa), .b_i(fb), .c_i(ia), .d_i(ib),
      .sum_o(s_a[k]), .carry_o(c_a[k])
    );
  end

  // path C: feedback renormalised up by one block
  logic [W-1:0] s_c, c_c, ic_s, ic_c;
  assign ic_s = c_shift_in_i ? sra32(s_in_i) : s_in_i;
  assign ic_c = c_shift_in_i ? sra32(c_in_i) : c_in_i;
  sca_csa42 #(.W(W)) u_csa_c (
    .a_i(shl32(s_fb_i)), .b_i(shl32(c_fb_i)), .c_i(ic_s), .d_i(ic_c),
    .sum_o(s_c), .carry_o(c_c)
  );

  logic [W-1:0] s_pick, c_pick, v;
  logic         ovf;

  always_comb begin
    if (path_i == PATH_C) begin
      s_pick = s_c;
      c_pick = c_c;
    end else begin
      unique case (aln_i)
        ALN_IN:  begin s_pick = s_a[1]; c_pick = c_a[1]; end
        ALN_FB:  begin s_pick = s_a[2]; c_pick = c_a[2]; end
        default: begin s_pick = s_a[0]; c_pick = c_a[0]; end
      endcase
    end
  end

  // overflow resolved after the mux
  assign v   = s_pick + c_pick;
  assign ovf = v[W-1] ^ v[W-2];

  always_comb begin
    s_res_o   = s_pick;
    c_res_o   = c_pick;
    exp_res_o = exp_base_i;
    if (ovf) begin
      s_res_o   = sra32(v);
      c_res_o   = '0;
      exp_res_o = (exp_base_i == EXP_MAX) ? exp_base_i : exp_base_i + EW'(1);
    end
  end
endmodule

// File: rtl/sca_acc.sv
module sca_acc
  import sca_pkg::*;
#(
  parameter int MW = sca_pkg::MANT_W,
  parameter int EW = sca_pkg::EXP_W,
  parameter int SH = sca_pkg::BLK_SH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          acc_en_i,
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] sum_i,
  input  logic [MW-1:0] carry_i,
  output logic [EW-1:0] exp_o,
  output logic [MW-1:0] sum_o,
  output logic [MW-1:0] carry_o
);
  logic [EW-1:0] exp_q, exp_d, exp_base, exp_m;
  logic [MW-1:0] s_q, c_q, s_d, c_d, s_m, c_m;
  logic          fb_zero, fb_renorm, c_shift_in, keep_in;
  path_e         path;
  aln_e          aln;

  sca_fb_probe #(.W(MW), .SH(SH)) u_probe (
    .sum_i(s_q), .carry_i(c_q), .zero_o(fb_zero), .renorm_o(fb_renorm)
  );

  sca_path_sel #(.EW(EW)) u_sel (
    .exp_fb_i(exp_q), .exp_in_i(exp_i), .zero_i(fb_zero), .renorm_i(fb_renorm),
    .path_o(path), .aln_o(aln), .c_shift_in_o(c_shift_in), .keep_in_o(keep_in),
    .exp_base_o(exp_base)
  );

  sca_merge #(.W(MW), .SH(SH), .EW(EW)) u_merge (
    .s_fb_i(s_q), .c_fb_i(c_q), .s_in_i(sum_i), .c_in_i(carry_i),
    .path_i(path), .aln_i(aln), .c_shift_in_i(c_shift_in), .exp_base_i(exp_base),
    .s_res_o(s_m), .c_res_o(c_m), .exp_res_o(exp_m)
  );

  always_comb begin
    unique case (path)
      PATH_D: begin exp_d = exp_i; s_d = sum_i; c_d = carry_i; end
      PATH_B: begin
        exp_d = keep_in ? exp_i   : exp_q;
        s_d   = keep_in ? sum_i   : s_q;
        c_d   = keep_in ? carry_i : c_q;
      end
      default: begin exp_d = exp_m; s_d = s_m; c_d = c_m; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      s_q   <= '0;
      c_q   <= '0;
    end else if (clear_i) begin
      exp_q <= '0;
      s_q   <= '0;
      c_q   <= '0;
    end else if (acc_en_i) begin
      exp_q <= exp_d;
      s_q   <= s_d;
      c_q   <= c_d;
    end
  end

  assign exp_o   = exp_q;
  assign sum_o   = s_q;
  assign carry_o = c_q;
endmodule

// File: rtl/sca_acc_chk.sv
module sca_acc_chk #(
  parameter int MW = sca_pkg::MANT_W,
  parameter int EW = sca_pkg::EXP_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          acc_en_i,
  input logic [EW-1:0] exp_i,
  input logic [MW-1:0] sum_i,
  input logic [MW-1:0] carry_i,
  input logic [EW-1:0] exp_o,
  input logic [MW-1:0] sum_o,
  input logic [MW-1:0] carry_o
);
  logic [MW-1:0] fb_val;
  logic          take;

  assign fb_val = sum_o + carry_o;
  assign take   = !clear_i && acc_en_i;

  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (exp_o == '0 && sum_o == '0 && carry_o == '0));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !acc_en_i) |=> ($stable(exp_o) && $stable(sum_o) && $stable(carry_o)));

  a_r3_zero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && fb_val == '0) |=>
      (exp_o == $past(exp_i) && sum_o == $past(sum_i) && carry_o == $past(carry_i)));

  a_r6_keep_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && fb_val != '0 && {1'b0, exp_o} >= {1'b0, exp_i} + 4'd3) |=>
      ($stable(exp_o) && $stable(sum_o) && $stable(carry_o)));

  a_r6_keep_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && fb_val != '0 && {1'b0, exp_i} >= {1'b0, exp_o} + 4'd2) |=>
      (exp_o == $past(exp_i) && sum_o == $past(sum_i) && carry_o == $past(carry_i)));

  // R8/R9: equal exponents move the exponent by at most one step, never wrapping
  a_r8_exp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && fb_val != '0 && exp_o == exp_i) |=>
      (exp_o == $past(exp_o) || exp_o == $past(exp_o) + EW'(1)) && exp_o >= $past(exp_o));
endmodule

bind sca_acc sca_acc_chk u_chk (.*);

// File: tb/sim_sca_acc.sv
module sim_sca_acc;
  import sca_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W  = MANT_W;
  localparam int SH = BLK_SH;
  localparam int NROW = 23;

  typedef struct packed {
    logic         clr;
    logic         en;
    logic [2:0]   e;
    logic [W-1:0] s;
    logic [W-1:0] c;
    logic [2:0]   ex;
    logic [7:0]   req;
  } row_t;

  localparam logic [W-1:0] MAXP = 55'h1F_FFFF_FFFF_FFFF;

  localparam row_t ROWS [NROW] = '{
    '{1'b0, 1'b1, 3'd3, 55'd100, 55'd20, 3'd3, 8'd3},              // R3 load into zero
    '{1'b0, 1'b1, 3'd3, 55'd5, 55'd0, 3'd3, 8'd4},                 // R4 equal exp
    '{1'b0, 1'b1, 3'd2, 55'd7, 55'd0, 3'd2, 8'd7},                 // R7 renorm, diff 1
    '{1'b0, 1'b1, 3'd3, 55'd1000, 55'd0, 3'd3, 8'd5},              // R5 feedback shifted
    '{1'b0, 1'b1, 3'd0, 55'd123, 55'd0, 3'd3, 8'd6},               // R6 far, keep fb
    '{1'b0, 1'b1, 3'd5, 55'h55, 55'h11, 3'd5, 8'd6},               // R6 incoming +2, keep in
    '{1'b0, 1'b1, 3'd3, 55'h5_0000_0000, 55'd0, 3'd4, 8'd7},       // R7 renorm, diff 2
    '{1'b0, 1'b1, 3'd2, 55'd1, 55'd0, 3'd4, 8'd6},                 // R6 diff 2, no renorm
    '{1'b0, 1'b1, 3'd3, 55'h7_0000_0000, 55'd0, 3'd4, 8'd5},       // R5 incoming shifted
    '{1'b0, 1'b1, 3'd4, MAXP, 55'd0, 3'd5, 8'd8},                  // R8 overflow step
    '{1'b1, 1'b0, 3'd6, 55'd9, 55'd9, 3'd0, 8'd1},                 // R1 clear beats enable low
    '{1'b0, 1'b1, 3'd7, MAXP, 55'd0, 3'd7, 8'd3},                  // R3
    '{1'b0, 1'b1, 3'd7, MAXP, 55'd0, 3'd7, 8'd9},                  // R9 saturate
    '{1'b1, 1'b1, 3'd1, 55'd4, 55'd4, 3'd0, 8'd1},                 // R1
    '{1'b0, 1'b1, 3'd1, 55'h7F_FFFF_FFFF_FFCE, 55'd0, 3'd1, 8'd3}, // R3 negative load
    '{1'b0, 1'b1, 3'd1, 55'd20, 55'd0, 3'd1, 8'd4},                // R4 negative sum
    '{1'b0, 1'b1, 3'd0, 55'd9, 55'd0, 3'd0, 8'd7},                 // R7 negative renorm
    '{1'b0, 1'b0, 3'd5, 55'd77, 55'd3, 3'd0, 8'd2},                // R2 hold
    '{1'b1, 1'b1, 3'd0, 55'd0, 55'd0, 3'd0, 8'd1},                 // R1
    '{1'b0, 1'b1, 3'd3, 55'h40_0000, 55'd0, 3'd3, 8'd3},           // R3
    '{1'b0, 1'b1, 3'd2, 55'h1_0000_0000, 55'd0, 3'd3, 8'd7},       // R7 exactly 31: no renorm
    '{1'b0, 1'b1, 3'd3, 55'h7F_FFFF_FFBF_FFFF, 55'd0, 3'd3, 8'd4}, // R4 cancels to zero
    '{1'b0, 1'b1, 3'd0, 55'h33, 55'h2, 3'd0, 8'd3}                 // R3 zero beats far exp
  };

  logic         clk_i = 1'b0;
  logic         rst_ni, clear_i, acc_en_i;
  logic [2:0]   exp_i, exp_o;
  logic [W-1:0] sum_i, carry_i, sum_o, carry_o;
  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sca_acc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .acc_en_i(acc_en_i),
    .exp_i(exp_i), .sum_i(sum_i), .carry_i(carry_i),
    .exp_o(exp_o), .sum_o(sum_o), .carry_o(carry_o)
  );

  function automatic logic [W-1:0] sra_b(input logic [W-1:0] x);
    logic signed [W-1:0] t;
    t = x;
    return t >>> SH;
  endfunction

  function automatic logic [W-1:0] shl_b(input logic [W-1:0] x);
    return x << SH;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference from the requirements, using the observed state words
  task automatic model_next(
    input  logic [2:0] e8, input logic [W-1:0] s8, input logic [W-1:0] c8,
    input  logic [2:0] e7, input logic [W-1:0] s7, input logic [W-1:0] c7,
    output logic [2:0] ee, output logic [W-1:0] es, output logic [W-1:0] ec,
    output logic exact);
    logic [W-1:0] fb, a, b, x, y, v;
    logic [2:0]   eb;
    logic         ren, arith;
    fb  = s8 + c8;
    ren = (fb[W-1:W-SH-1] == '0) || (fb[W-1:W-SH-1] == '1);
    a = s8; b = c8; x = s7; y = c7; eb = e8;
    ee = e8; es = s8; ec = c8; exact = 1'b1; arith = 1'b0;
    if (fb == '0) begin
      ee = e7; es = s7; ec = c7;
    end else if (e8 > e7) begin
      if (e8 - e7 == 3'd1) begin
        arith = 1'b1;
        if (ren) begin a = shl_b(s8); b = shl_b(c8); eb = e8 - 3'd1; end
        else begin x = sra_b(s7); y = sra_b(c7); end
      end else if (e8 - e7 == 3'd2 && ren) begin
        arith = 1'b1;
        a = shl_b(s8); b = shl_b(c8); x = sra_b(s7); y = sra_b(c7); eb = e8 - 3'd1;
      end
    end else if (e8 == e7) begin
      arith = 1'b1;
    end else if (e7 - e8 == 3'd1) begin
      arith = 1'b1; a = sra_b(s8); b = sra_b(c8); eb = e7;
    end else begin
      ee = e7; es = s7; ec = c7;
    end
    if (arith) begin
      exact = 1'b0;
      v = a + b + x + y;
      if (v[W-1] != v[W-2]) begin
        v  = sra_b(v);
        eb = (eb == 3'd7) ? eb : eb + 3'd1;
      end
      ee = eb; es = v; ec = '0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0]   ee;
    logic [W-1:0] es, ec, vo;
    logic         ex;
    string        rq;
    rst_ni = 1'b0; clear_i = 1'b0; acc_en_i = 1'b0;
    exp_i = '0; sum_i = '0; carry_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(exp_o == 3'd0 && sum_o == '0 && carry_o == '0, "R1", "reset state", {exp_o, sum_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk_i);
      rq = $sformatf("R%0d", ROWS[i].req);
      if (ROWS[i].clr) begin
        ee = '0; es = '0; ec = '0; ex = 1'b1;
      end else if (!ROWS[i].en) begin
        ee = exp_o; es = sum_o; ec = carry_o; ex = 1'b1;
      end else begin
        model_next(exp_o, sum_o, carry_o, ROWS[i].e, ROWS[i].s, ROWS[i].c, ee, es, ec, ex);
      end
      clear_i = ROWS[i].clr; acc_en_i = ROWS[i].en;
      exp_i = ROWS[i].e; sum_i = ROWS[i].s; carry_i = ROWS[i].c;
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      vo = sum_o + carry_o;
      chk(exp_o == ROWS[i].ex, rq, $sformatf("row %0d exponent", i), 64'(exp_o), 64'(ROWS[i].ex));
      chk(exp_o == ee, rq, $sformatf("row %0d model exponent", i), 64'(exp_o), 64'(ee));
      chk(vo == es + ec, rq, $sformatf("row %0d value", i), 64'(vo), 64'(es + ec));
      if (ex)
        chk(sum_o == es && carry_o == ec, rq, $sformatf("row %0d words", i), 64'(sum_o), 64'(es));
    end

    // R1: asynchronous reset acts between edges
    @(negedge clk_i);
    acc_en_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    chk(exp_o == 3'd0 && sum_o == '0 && carry_o == '0, "R1", "async reset", 64'(sum_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3: first operand after reset is loaded as is
    acc_en_i = 1'b1; exp_i = 3'd6; sum_i = 55'h1234; carry_i = 55'h10;
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    chk(exp_o == 3'd6 && sum_o == 55'h1234 && carry_o == 55'h10, "R3", "load after reset",
        64'(sum_o), 64'h1234);
    acc_en_i = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule